// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel buses, called A and B, and passes data between them either straight through or from a holding register. The data path is cut into independent lanes (two lanes of eight bits by default). Each lane has its own control set: an active-low output enable, a direction bit, one capture strobe for each direction, and one live-or-stored select for each direction. Each lane holds one register that samples the A bus and one that samples the B bus.

Each bus is modelled as three vectors: an input vector carrying what is seen on the pins, an output vector, and a per-bit output-enable vector. A pad ring outside this block turns these into real tri-state pins. All logic runs on one system clock. A capture strobe counts as a rising edge when the clock finds it high after finding it low on the edge before. The register loads on that same clock edge. Captures do not depend on the output enable or the direction, so a lane can store data while it is isolated from both buses.

Top module: `dual_lane_xcvr`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), both registers of every lane hold zero.
- R2: On the clock edge where a lane's cap_ab is first seen high after being low, that lane's A register loads the lane's slice of a_in, whatever oe_n and dir are.
- R3: On the clock edge where a lane's cap_ba is first seen high after being low, that lane's B register loads the lane's slice of b_in, whatever oe_n and dir are.
- R4: A strobe that stays high across further clock edges causes no further loads. A new load needs the strobe to go low and then high again.
- R5: With oe_n high (isolation), a lane drives neither bus: its bits of a_oe and b_oe are 0. Both registers still load on strobe edges.
- R6: With oe_n low, dir low and sel_ba low, the lane's a_oe bits are all 1, its b_oe bits are 0, and a_out follows b_in in the same cycle with no clock.
- R7: With oe_n low, dir low and sel_ba high, a_out carries the lane's B register.
- R8: With oe_n low, dir high and sel_ab low, the lane's b_oe bits are all 1, its a_oe bits are 0, and b_out follows a_in in the same cycle with no clock.
- R9: With oe_n low, dir high and sel_ab high, b_out carries the lane's A register.
- R10: Within one lane, a_oe and b_oe are never active together.
- R11: Lane i is controlled only by bit i of each control vector and covers data bits [i*LANE_W +: LANE_W]. Controls of one lane have no effect on another lane.
- R12: An output vector reads zero on every bit whose output enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n | input | LANES | Per-lane output enable, active low |
| dir | input | LANES | Per-lane direction: 0 drives A, 1 drives B |
| cap_ab | input | LANES | Per-lane strobe that loads the A register from a_in |
| cap_ba | input | LANES | Per-lane strobe that loads the B register from b_in |
| sel_ab | input | LANES | Per-lane source for B: 0 live a_in, 1 A register |
| sel_ba | input | LANES | Per-lane source for A: 0 live b_in, 1 B register |
| a_in | input | LANES*LANE_W | Value present on the A bus |
| a_out | output | LANES*LANE_W | Value to drive onto the A bus |
| a_oe | output | LANES*LANE_W | Per-bit drive enable for the A bus |
| b_in | input | LANES*LANE_W | Value present on the B bus |
| b_out | output | LANES*LANE_W | Value to drive onto the B bus |
| b_oe | output | LANES*LANE_W | Per-bit drive enable for the B bus |

## Verification
The bench uses the default parameters: two lanes of eight bits. With two lanes, one lane can be set to drive A while the other drives B or sits isolated. The bench can then show that strobes and selects in one lane leave the other lane's slice and registers unchanged. Eight-bit lanes let distinct byte patterns reveal a swapped or misplaced slice. Sixteen combinations of enable and direction across the two lanes cover every drive state of each lane.

// File: rtl/xcvr_pkg.sv
// Shared types for the registered bus transceiver.
// Assumes: the enable input is active low and the direction bit selects the driven side.
package xcvr_pkg;

    // Which side of a lane, if any, is being driven.
    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_A    = 2'd1,
        DRV_B    = 2'd2
    } drive_e;

    // Decode one lane's enable and direction into a drive state.
    function automatic drive_e lane_mode(input logic en_n, input logic to_b);
        if (en_n)
            return DRV_NONE;
        else if (to_b)
            return DRV_B;
        else
            return DRV_A;
    endfunction

endpackage

// File: rtl/xcvr_rise_det.sv
// Rising-edge detector for a capture strobe sampled on the system clock.
// Assumes: the strobe is synchronous to clk. After reset, a strobe that is
// already high does not count as an edge.
module xcvr_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);

    logic strobe_q;

    // Remember the strobe level from the previous clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobe_q <= 1'b1;
        else
            strobe_q <= strobe;
    end

    // An edge is the strobe high now and low at the previous sample.
    always_comb rise = strobe & ~strobe_q;

endmodule

// File: rtl/xcvr_store_reg.sv
// Holding register for one lane and one direction.
// Assumes: load is a single-cycle pulse; the register clears on synchronous reset.
module xcvr_store_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Clear on reset, otherwise take the bus value when loaded.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

endmodule

// File: rtl/xcvr_lane.sv
// One lane of the transceiver: two holding registers, their strobe edge
// detectors, and the output and enable logic for both buses.
// Assumes: a_in and b_in reflect the pins at all times, including while driven.
module xcvr_lane #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oe_n,
    input  logic              dir,
    input  logic              cap_ab,
    input  logic              cap_ba,
    input  logic              sel_ab,
    input  logic              sel_ba,
    input  logic [LANE_W-1:0] a_in,
    input  logic [LANE_W-1:0] b_in,
    output logic [LANE_W-1:0] a_out,
    output logic [LANE_W-1:0] a_oe,
    output logic [LANE_W-1:0] b_out,
    output logic [LANE_W-1:0] b_oe,
    output logic [LANE_W-1:0] a_store,
    output logic [LANE_W-1:0] b_store
);

    logic            a_load;
    logic            b_load;
    xcvr_pkg::drive_e mode;

    xcvr_rise_det u_a_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cap_ab),
        .rise   (a_load)
    );

    xcvr_rise_det u_b_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cap_ba),
        .rise   (b_load)
    );

    xcvr_store_reg #(.WIDTH(LANE_W)) u_a_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (a_load),
        .d     (a_in),
        .q     (a_store)
    );

    xcvr_store_reg #(.WIDTH(LANE_W)) u_b_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (b_load),
        .d     (b_in),
        .q     (b_store)
    );

    // Decode the drive state of this lane.
    always_comb mode = xcvr_pkg::lane_mode(oe_n, dir);

    // Steer live or stored data to the driven side; the undriven side reads zero.
    always_comb begin
        a_out = '0;
        b_out = '0;
        a_oe  = '0;
        b_oe  = '0;
        unique case (mode)
            xcvr_pkg::DRV_A: begin
                a_oe  = '1;
                a_out = sel_ba ? b_store : b_in;
            end
            xcvr_pkg::DRV_B: begin
                b_oe  = '1;
                b_out = sel_ab ? a_store : a_in;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/dual_lane_xcvr.sv
// Top of the registered bidirectional transceiver: LANES independent lanes,
// each LANE_W bits wide, each with its own control set.
// Assumes: all controls are synchronous to clk; a pad ring outside resolves
// the in/out/enable vectors into tri-state pins.
module dual_lane_xcvr #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] oe_n,
    input  logic [LANES-1:0] dir,
    input  logic [LANES-1:0] cap_ab,
    input  logic [LANES-1:0] cap_ba,
    input  logic [LANES-1:0] sel_ab,
    input  logic [LANES-1:0] sel_ba,
    input  logic [W-1:0]     a_in,
    output logic [W-1:0]     a_out,
    output logic [W-1:0]     a_oe,
    input  logic [W-1:0]     b_in,
    output logic [W-1:0]     b_out,
    output logic [W-1:0]     b_oe
);

    logic [W-1:0] a_store;
    logic [W-1:0] b_store;

    // One lane per control bit, each owning its slice of both buses.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        xcvr_lane #(.LANE_W(LANE_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .oe_n    (oe_n[g]),
            .dir     (dir[g]),
            .cap_ab  (cap_ab[g]),
            .cap_ba  (cap_ba[g]),
            .sel_ab  (sel_ab[g]),
            .sel_ba  (sel_ba[g]),
            .a_in    (a_in[g*LANE_W +: LANE_W]),
            .b_in    (b_in[g*LANE_W +: LANE_W]),
            .a_out   (a_out[g*LANE_W +: LANE_W]),
            .a_oe    (a_oe[g*LANE_W +: LANE_W]),
            .b_out   (b_out[g*LANE_W +: LANE_W]),
            .b_oe    (b_oe[g*LANE_W +: LANE_W]),
            .a_store (a_store[g*LANE_W +: LANE_W]),
            .b_store (b_store[g*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/xcvr_checker.sv
// Property checker for dual_lane_xcvr, attached with bind.
// Assumes: the holding registers of the top are visible as a_store and b_store.
module xcvr_checker #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int W     = LANES * LANE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LANES-1:0] oe_n,
    input logic [LANES-1:0] dir,
    input logic [LANES-1:0] cap_ab,
    input logic [LANES-1:0] cap_ba,
    input logic [LANES-1:0] sel_ab,
    input logic [LANES-1:0] sel_ba,
    input logic [W-1:0]     a_in,
    input logic [W-1:0]     a_out,
    input logic [W-1:0]     a_oe,
    input logic [W-1:0]     b_in,
    input logic [W-1:0]     b_out,
    input logic [W-1:0]     b_oe,
    input logic [W-1:0]     a_store,
    input logic [W-1:0]     b_store
);

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R10: a lane never enables both sides
        a_r10_one_side: assert property (@(posedge clk) disable iff (!rst_n)
            !(a_oe[g*LANE_W] && b_oe[g*LANE_W]));

        // R5: isolation leaves both sides undriven
        a_r5_isolated: assert property (@(posedge clk) disable iff (!rst_n)
            oe_n[g] |-> (a_oe[g*LANE_W +: LANE_W] == '0 && b_oe[g*LANE_W +: LANE_W] == '0));

        // R2: a fresh rising strobe loads the A register from a_in
        a_r2_a_capture: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && cap_ab[g] && !$past(cap_ab[g]))
            |=> (a_store[g*LANE_W +: LANE_W] == $past(a_in[g*LANE_W +: LANE_W])));

        // R3: a fresh rising strobe loads the B register from b_in
        a_r3_b_capture: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && cap_ba[g] && !$past(cap_ba[g]))
            |=> (b_store[g*LANE_W +: LANE_W] == $past(b_in[g*LANE_W +: LANE_W])));

        // R4: a strobe held high does not reload
        a_r4_held_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_ab[g] && $past(cap_ab[g]) && $past(rst_n))
            |=> $stable(a_store[g*LANE_W +: LANE_W]));

        // R6: live path from B onto A
        a_r6_live_to_a: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_n[g] && !dir[g] && !sel_ba[g])
            |-> (a_out[g*LANE_W +: LANE_W] == b_in[g*LANE_W +: LANE_W]));

        // R7: stored path from the B register onto A
        a_r7_stored_to_a: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_n[g] && !dir[g] && sel_ba[g])
            |-> (a_out[g*LANE_W +: LANE_W] == b_store[g*LANE_W +: LANE_W]));

        // R9: stored path from the A register onto B
        a_r9_stored_to_b: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_n[g] && dir[g] && sel_ab[g])
            |-> (b_out[g*LANE_W +: LANE_W] == a_store[g*LANE_W +: LANE_W]));
    end

    // R12: undriven output bits read zero
    a_r12_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_out & ~a_oe) == '0) && ((b_out & ~b_oe) == '0));

endmodule

bind dual_lane_xcvr xcvr_checker #(.LANES(LANES), .LANE_W(LANE_W)) u_xcvr_checker (.*);

// File: tb/dual_lane_xcvr_bench.sv
// Directed bench for dual_lane_xcvr: one task per scenario.
module dual_lane_xcvr_bench;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int W      = LANES * LANE_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [LANES-1:0] oe_n, dir, cap_ab, cap_ba, sel_ab, sel_ba;
    logic [W-1:0]     a_in, b_in;
    logic [W-1:0]     a_out, a_oe, b_out, b_oe;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    dual_lane_xcvr #(.LANES(LANES), .LANE_W(LANE_W)) u_dual_lane_xcvr (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
        .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Wait for a clock edge, then step clear of it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        oe_n = '1; dir = '0; cap_ab = '0; cap_ba = '0; sel_ab = '0; sel_ba = '0;
        #1;
    endtask

    // R1: registers clear on reset, seen through the stored paths.
    task automatic t_reset();
        oe_n = '0; dir = '0; sel_ba = '1; b_in = 16'hFFFF; #1;
        chk("R1 B register after reset", a_out, 16'h0000);
        dir = '1; sel_ab = '1; a_in = 16'hFFFF; #1;
        chk("R1 A register after reset", b_out, 16'h0000);
        idle();
    endtask

    // R6, R8, R12: live paths follow inputs without a clock.
    task automatic t_live();
        oe_n = '0; dir = '0; sel_ba = '0; b_in = 16'h5AC3; #1;
        chk("R6 a_out live", a_out, 16'h5AC3);
        chk("R6 a_oe", a_oe, 16'hFFFF);
        chk("R6 b_oe", b_oe, 16'h0000);
        chk("R12 b_out quiet", b_out, 16'h0000);
        b_in = 16'h0F96; #1;
        chk("R6 a_out follows change", a_out, 16'h0F96);
        dir = '1; sel_ab = '0; a_in = 16'h7E21; #1;
        chk("R8 b_out live", b_out, 16'h7E21);
        chk("R8 b_oe", b_oe, 16'hFFFF);
        chk("R8 a_oe", a_oe, 16'h0000);
        chk("R12 a_out quiet", a_out, 16'h0000);
        a_in = 16'h8844; #1;
        chk("R8 b_out follows change", b_out, 16'h8844);
        idle();
    endtask

    // R2, R5, R9: capture A while isolated, then replay it onto B.
    task automatic t_store_a();
        oe_n = '1; a_in = 16'hA55A; cap_ab = '1; #1;
        chk("R5 a_oe isolated", a_oe, 16'h0000);
        chk("R5 b_oe isolated", b_oe, 16'h0000);
        chk("R12 isolated outputs", a_out | b_out, 16'h0000);
        tick();
        cap_ab = '0; a_in = 16'h0000;
        oe_n = '0; dir = '1; sel_ab = '1; #1;
        chk("R2 R9 A register replayed", b_out, 16'hA55A);
        idle();
    endtask

    // R3, R7: capture B while B is the driven side, then replay onto A.
    task automatic t_store_b();
        oe_n = '0; dir = '1; b_in = 16'h1234; cap_ba = '1; #1;
        tick();
        cap_ba = '0; b_in = 16'hFFFF;
        dir = '0; sel_ba = '1; #1;
        chk("R3 R7 B register replayed", a_out, 16'h1234);
        idle();
    endtask

    // R4: a held strobe loads once; a new rising edge loads again.
    task automatic t_held();
        a_in = 16'h1111; cap_ab = '1; #1;
        tick();
        a_in = 16'h2222;
        tick();
        tick();
        oe_n = '0; dir = '1; sel_ab = '1; #1;
        chk("R4 no reload while held", b_out, 16'h1111);
        cap_ab = '0;
        tick();
        cap_ab = '1;
        tick();
        cap_ab = '0; #1;
        chk("R4 reload after new edge", b_out, 16'h2222);
        idle();
    endtask

    // R11: lanes driven in opposite directions and captured separately.
    task automatic t_lanes();
        oe_n = 2'b00; dir = 2'b10; sel_ab = '0; sel_ba = '0;
        a_in = 16'hC3_3C; b_in = 16'h96_69; #1;
        chk("R11 a_oe per lane", a_oe, 16'h00FF);
        chk("R11 b_oe per lane", b_oe, 16'hFF00);
        chk("R11 a_out lane0 only", a_out, 16'h0069);
        chk("R11 b_out lane1 only", b_out, 16'hC300);
        // Load B register of lane 1 only, then read both lanes' B registers.
        b_in = 16'hBEEF; cap_ba = 2'b10; #1;
        tick();
        cap_ba = '0; b_in = 16'h0000;
        oe_n = 2'b00; dir = 2'b00; sel_ba = 2'b11; #1;
        chk("R11 lane1 load leaves lane0", a_out, 16'hBE34);
        idle();
    endtask

    // R10: every enable and direction combination over both lanes.
    task automatic t_combos();
        for (int k = 0; k < 16; k++) begin
            logic [W-1:0] ea, eb;
            oe_n = k[1:0]; dir = k[3:2]; #1;
            ea = '0; eb = '0;
            for (int l = 0; l < LANES; l++) begin
                if (!oe_n[l] && !dir[l]) ea[l*LANE_W +: LANE_W] = '1;
                if (!oe_n[l] &&  dir[l]) eb[l*LANE_W +: LANE_W] = '1;
            end
            chk("R10 no overlap", a_oe & b_oe, 16'h0000);
            chk("R10 a_oe pattern", a_oe, ea);
            chk("R10 b_oe pattern", b_oe, eb);
        end
        idle();
    endtask

    initial begin
        rst_n = 1'b0; a_in = '0; b_in = '0;
        idle();
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_live();
        t_store_a();
        t_store_b();
        t_held();
        t_lanes();
        t_combos();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule